// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block gathers up to 32 level-sensitive interrupt lines and drives two processor request outputs: a normal request (`irq_o`) and a fast request (`fiq_o`). All lines share one raw level vector. Each output has its own enable mask, so a source can be routed to the normal request, to the fast request, to both, or to neither. Software changes a mask only through separate set and clear addresses. Writing 1 to a bit at a set address turns that bit on. Writing 1 to a bit at a clear address turns it off. Bits written as 0 leave the mask as it was.

The inputs are registered on every clock. Source 0 is also fed by a software latch, so software can post an interrupt to itself. Status words return either the raw levels or the levels after masking. The register port is word addressed, and read data is a combinational function of the address. Several controllers can be cascaded: the `irq_o` of one controller drives a source input of another.

Top module: `irqc_top`

## Requirements
- R1: After reset, both enable masks and the software latch are zero. `irq_o` and `fiq_o` are low, and words 2 and 10 read 0.
- R2: Words 1 and 9 both return the raw level vector. The raw level of a line is its input as sampled at the last clock edge. Bit 0 is that sample ORed with the software latch.
- R3: A write to word 2 ORs the write data into the normal-request mask. A read of word 2 returns that mask.
- R4: A write to word 3 clears every normal-request mask bit whose write-data bit is 1. All other mask bits are left unchanged.
- R5: A write to word 10 ORs the write data into the fast-request mask, and a read of word 10 returns that mask. A write to word 11 clears every fast-request mask bit whose write-data bit is 1.
- R6: Word 0 reads the raw levels ANDed with the normal-request mask. Word 8 reads the raw levels ANDed with the fast-request mask.
- R7: `irq_o` is high exactly when raw AND normal mask is nonzero. `fiq_o` is high exactly when raw AND fast mask is nonzero. The two outputs are independent of each other.
- R8: Writing data with bit 0 = 1 to word 4 sets the software latch, and writing data with bit 0 = 1 to word 5 clears it. Writes to either word with bit 0 = 0 have no effect. A read of word 4 returns only raw bit 0.
- R9: Source 0 stays asserted while either external input 0 or the software latch is high. Clearing the latch while input 0 is high leaves raw bit 0 at 1.
- R10: Reads of words 3, 5 and 11, and of any word not listed in R2 to R8, return 0.
- R11: Writes to words 0, 1, 8 and 9, and to unlisted words, change neither mask nor the latch.
- R12: A change on a source input reaches the raw status and the outputs after exactly one rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 32 | Level-sensitive interrupt source lines |
| bus_we | input | 1 | Write strobe for the current word |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench aims at the places where one mask could leak into the other. It enables a source on one output only and checks that the other output stays low; a design that shared or crossed the masks would raise both. It clears the software latch while external input 0 is held high, which catches a design that lets the clear override the pin. It writes to the status words and to unlisted words and then reads the masks back, which exposes decode aliasing such as treating word 0 like word 2. It also issues latch writes with bit 0 = 0, which must do nothing; a design that acted on any write to words 4 and 5 would fail there.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // word offsets; software depends on these positions
  localparam int W_IRQ_STAT  = 0;
  localparam int W_IRQ_RAW   = 1;
  localparam int W_IRQ_SET   = 2;
  localparam int W_IRQ_CLR   = 3;
  localparam int W_SOFT_SET  = 4;
  localparam int W_SOFT_CLR  = 5;
  localparam int W_FIQ_STAT  = 8;
  localparam int W_FIQ_RAW   = 9;
  localparam int W_FIQ_SET   = 10;
  localparam int W_FIQ_CLR   = 11;

  typedef struct packed {
    logic irq_set;
    logic irq_clr;
    logic fiq_set;
    logic fiq_clr;
    logic soft_set;
    logic soft_clr;
  } wr_strobe_t;
endpackage

// File: rtl/irqc_src_stage.sv
module irqc_src_stage #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            soft_set,
  input  logic            soft_clr,
  output logic [NSRC-1:0] raw_o
);
  logic [NSRC-1:0] src_q;
  logic            soft_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= '0;
      soft_q <= 1'b0;
    end else begin
      src_q <= src_i;
      if (soft_set)      soft_q <= 1'b1;
      else if (soft_clr) soft_q <= 1'b0;
    end
  end

  always_comb begin
    raw_o    = src_q;
    raw_o[0] = src_q[0] | soft_q;
  end

  a_r8_soft_set: assert property (@(posedge clk) disable iff (!rst_n)
    soft_set |=> raw_o[0]);
  a_r9_pin_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i[0] && soft_clr) |=> raw_o[0]);
  a_r12_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_q |=> (raw_o[NSRC-1:1] == $past(src_i[NSRC-1:1])));
endmodule

// File: rtl/irqc_mask_bank.sv
module irqc_mask_bank #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic            clr_en,
  input  logic [NSRC-1:0] bits,
  output logic [NSRC-1:0] mask_o
);
  function automatic logic [NSRC-1:0] next_mask(
    input logic [NSRC-1:0] cur, input logic s, input logic c,
    input logic [NSRC-1:0] b);
    logic [NSRC-1:0] r;
    r = cur;
    if (s) r = r | b;
    if (c) r = r & ~b;
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) mask_o <= '0;
    else        mask_o <= next_mask(mask_o, set_en, clr_en, bits);
  end

  a_r3_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !clr_en) |=> ((mask_o & $past(bits)) == $past(bits)));
  a_r4_clr_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en) |=> ((mask_o & $past(bits)) == '0));
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && !clr_en) |=> $stable(mask_o));
endmodule

// File: rtl/irqc_regport.sv
module irqc_regport
  import irqc_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [NSRC-1:0]   raw,
  input  logic [NSRC-1:0]   irq_mask,
  input  logic [NSRC-1:0]   fiq_mask,
  output wr_strobe_t        stb,
  output logic [DATA_W-1:0] rdata
);
  function automatic logic [DATA_W-1:0] widen(input logic [NSRC-1:0] v);
    logic [DATA_W-1:0] r;
    r = '0;
    r[NSRC-1:0] = v;
    return r;
  endfunction

  always_comb begin
    stb = '0;
    if (bus_we) begin
      unique case (bus_addr)
        ADDR_W'(W_IRQ_SET):  stb.irq_set  = 1'b1;
        ADDR_W'(W_IRQ_CLR):  stb.irq_clr  = 1'b1;
        ADDR_W'(W_FIQ_SET):  stb.fiq_set  = 1'b1;
        ADDR_W'(W_FIQ_CLR):  stb.fiq_clr  = 1'b1;
        ADDR_W'(W_SOFT_SET): stb.soft_set = bus_wdata[0];
        ADDR_W'(W_SOFT_CLR): stb.soft_clr = bus_wdata[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (bus_addr)
      ADDR_W'(W_IRQ_STAT): rdata = widen(raw & irq_mask);
      ADDR_W'(W_IRQ_RAW),
      ADDR_W'(W_FIQ_RAW):  rdata = widen(raw);
      ADDR_W'(W_IRQ_SET):  rdata = widen(irq_mask);
      ADDR_W'(W_SOFT_SET): rdata = DATA_W'(raw[0]);
      ADDR_W'(W_FIQ_STAT): rdata = widen(raw & fiq_mask);
      ADDR_W'(W_FIQ_SET):  rdata = widen(fiq_mask);
      default:             rdata = '0;
    endcase
  end

  always_comb begin
    a_r10_clear_words_read_zero: assert (!(bus_addr == ADDR_W'(W_IRQ_CLR) ||
      bus_addr == ADDR_W'(W_FIQ_CLR) || bus_addr == ADDR_W'(W_SOFT_CLR)) || rdata == '0);
    a_r8_latch_strobes_exclusive: assert ($countones({stb.soft_set, stb.soft_clr}) <= 1);
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              fiq_o
);
  wr_strobe_t      stb;
  logic [NSRC-1:0] raw, irq_mask, fiq_mask;
  logic [NSRC-1:0] wbits;

  assign wbits = bus_wdata[NSRC-1:0];

  irqc_src_stage #(.NSRC(NSRC)) u_src (
    .clk(clk), .rst_n(rst_n), .src_i(src_i),
    .soft_set(stb.soft_set), .soft_clr(stb.soft_clr), .raw_o(raw));

  irqc_mask_bank #(.NSRC(NSRC)) u_irq_mask (
    .clk(clk), .rst_n(rst_n), .set_en(stb.irq_set), .clr_en(stb.irq_clr),
    .bits(wbits), .mask_o(irq_mask));

  irqc_mask_bank #(.NSRC(NSRC)) u_fiq_mask (
    .clk(clk), .rst_n(rst_n), .set_en(stb.fiq_set), .clr_en(stb.fiq_clr),
    .bits(wbits), .mask_o(fiq_mask));

  irqc_regport #(.NSRC(NSRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_port (
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .raw(raw), .irq_mask(irq_mask), .fiq_mask(fiq_mask),
    .stb(stb), .rdata(bus_rdata));

  assign irq_o = |(raw & irq_mask);
  assign fiq_o = |(raw & fiq_mask);

  a_r7_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (irq_mask != '0));
  a_r7_fiq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> (fiq_mask != '0));
  a_r11_status_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (bus_addr == ADDR_W'(W_IRQ_STAT) || bus_addr == ADDR_W'(W_IRQ_RAW) ||
     bus_addr == ADDR_W'(W_FIQ_STAT) || bus_addr == ADDR_W'(W_FIQ_RAW)))
    |=> ($stable(irq_mask) && $stable(fiq_mask)));
endmodule

// File: tb/irqc_top_tb.sv
`timescale 1ns/1ps
module irqc_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_i = '0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, fiq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m_src = '0, m_ie = '0, m_fe = '0;
  logic        m_soft = 1'b0;

  always #2.5 clk = ~clk;

  irqc_top u_dut (.clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o));

  function automatic logic [31:0] m_raw();
    return m_src | {31'b0, m_soft};
  endfunction

  function automatic logic [31:0] exp_read(input int a);
    case (a)
      0:    return m_raw() & m_ie;
      1, 9: return m_raw();
      2:    return m_ie;
      4:    return {31'b0, m_raw()[0]};
      8:    return m_raw() & m_fe;
      10:   return m_fe;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_write(input int a, input logic [31:0] d);
    case (a)
      2:  m_ie = m_ie | d;
      3:  m_ie = m_ie & ~d;
      10: m_fe = m_fe | d;
      11: m_fe = m_fe & ~d;
      4:  if (d[0]) m_soft = 1'b1;
      5:  if (d[0]) m_soft = 1'b0;
      default: ;
    endcase
  endtask

  // one clock: drive, take the edge, update the model, check the outputs
  task automatic step(input bit we, input int a, input logic [31:0] d,
                      input logic [31:0] s, input string req);
    @(negedge clk);
    bus_we = we; bus_addr = 6'(a); bus_wdata = d; src_i = s;
    @(posedge clk);
    m_src = s;
    if (we) model_write(a, d);
    #1;
    chk({req, " irq_o"}, {31'b0, irq_o}, {31'b0, |(m_raw() & m_ie)});
    chk({req, " fiq_o"}, {31'b0, fiq_o}, {31'b0, |(m_raw() & m_fe)});
  endtask

  task automatic rd(input int a, input string req);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 6'(a);
    #1;
    chk(req, bus_rdata, exp_read(a));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 irq_o", {31'b0, irq_o}, 32'h0);
    chk("R1 fiq_o", {31'b0, fiq_o}, 32'h0);
    rd(2, "R1 irq mask"); rd(10, "R1 fiq mask");

    // R12 input latency, R2 raw
    @(negedge clk); src_i = 32'h0000_0100; #1;
    chk("R12 raw not yet", bus_rdata, 32'h0);
    step(0, 0, 0, 32'h0000_0100, "R12");
    rd(1, "R2 raw word1"); rd(9, "R2 raw word9");

    // R3 / R7 irq only
    step(1, 2, 32'h0000_0100, 32'h0000_0100, "R7 irq only");
    chk("R7 fiq stays low", {31'b0, fiq_o}, 32'h0);
    rd(2, "R3 irq mask"); rd(0, "R6 irq status");
    // R4 clear leaves other bits
    step(1, 2, 32'hF000_000F, 32'h0000_0100, "R3 or");
    step(1, 3, 32'h0000_0101, 32'h0000_0100, "R4 clear");
    rd(2, "R4 remaining mask");
    // R5 fiq mask
    step(1, 10, 32'h8000_0100, 32'h0000_0100, "R5 fiq set");
    rd(10, "R5 fiq mask"); rd(8, "R6 fiq status");
    step(1, 11, 32'h0000_0100, 32'h0000_0100, "R5 fiq clr");
    rd(10, "R5 fiq mask after clr");

    // R8 soft latch, bit0 = 0 ignored
    step(1, 4, 32'hFFFF_FFFE, 32'h0, "R8 soft set bit0 zero");
    rd(4, "R8 no latch");
    step(1, 4, 32'h1, 32'h0, "R8 soft set");
    rd(4, "R8 latch read"); rd(1, "R8 raw bit0");
    step(1, 5, 32'h0, 32'h0, "R8 clr bit0 zero");
    rd(4, "R8 still set");
    // R9 pin holds while latch cleared
    step(1, 5, 32'h1, 32'h1, "R9 clr with pin");
    rd(4, "R9 raw0 held");
    step(0, 0, 0, 32'h0, "R9 pin drop");
    rd(4, "R9 raw0 low");

    // R10 read zeros
    rd(3, "R10 word3"); rd(5, "R10 word5"); rd(11, "R10 word11"); rd(40, "R10 unlisted");
    // R11 status and unlisted writes ignored
    step(1, 0, 32'hFFFF_FFFF, 32'h0, "R11 w0");
    step(1, 1, 32'hFFFF_FFFF, 32'h0, "R11 w1");
    step(1, 8, 32'hFFFF_FFFF, 32'h0, "R11 w8");
    step(1, 9, 32'hFFFF_FFFF, 32'h0, "R11 w9");
    step(1, 40, 32'hFFFF_FFFF, 32'h0, "R11 w40");
    rd(2, "R11 irq mask"); rd(10, "R11 fiq mask"); rd(4, "R11 latch");

    // random mix
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 600; i++) begin
      int a;
      logic [31:0] d, s;
      a = ($urandom % 8 == 0) ? 16 + ($urandom % 40) : $urandom % 12;
      d = $urandom;
      s = ($urandom % 2) ? $urandom : ($urandom & 32'h0000_00FF);
      step($urandom % 2, a, d, s, "R7 random");
      rd($urandom % 16, "R6 random read");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule